// File: doc/BRIEF.md
# Elastic Stereo Sample Buffer with Selectable Lag

This block sits between a producer of stereo audio samples and a consumer that runs at its own rate. Each of them strobes once per sample in a shared system clock domain. The producer strobes whenever a new left/right pair is ready, and the consumer strobes whenever it wants one. The two rates drift freely against each other. A ring of stereo entries absorbs the drift while the read position trails the write position by a nominal lag. A one-bit mode input picks that lag: a short lag of a few entries for steady clocks, or a long lag of close to a hundred entries when the ratio between the clocks moves.

When the consumer catches up with the producer, or the producer laps the consumer, the block recentres the read position a full lag behind the write position and raises a mute flag. A change of the mode input recentres in the same way. The entries between the new read position and the write position hold stale data, so mute stays high until the consumer has read past them and taken the first sample written after the recentring. Read data is zero for as long as mute is high.

A build parameter can fix the block to the short lag. Its mode input then has no effect.

Top module: `elastic_sample_fifo`

## Requirements
- R1: After reset, mute is 1, both read data outputs are 0, and the block is in short mode with its occupancy equal to the short lag (5).
- R2: In short mode, after a recentring or reset, the first five accepted reads return zero with mute held. The sixth returns the first sample written at or after the recentring. Later reads return the written samples in order.
- R3: In long mode the lag is 96: after a recentring, reads 1 to 96 stay muted, and read 97 returns the first sample written after the recentring.
- R4: A read strobe while occupancy is zero (underflow) causes a recentring: mute is 1 on the next cycle and the read data is zero.
- R5: A write strobe without a read strobe while occupancy equals the depth (128) causes a recentring, and mute is 1 on the next cycle. The write of the 128th unread entry does not.
- R6: Mute falls only in the cycle after an accepted read. That read is the one that takes the first sample written at or after the recentring, and its data appears on the outputs in the same cycle as mute falls.
- R7: Whenever mute is 1, both read data outputs are 0, including cycles with no read strobe.
- R8: A change of the mode input (0 = short, 1 = long) recentres with the lag of the new mode and sets mute on the next cycle.
- R9: Simultaneous read and write strobes leave occupancy unchanged, and an unmuted stream at equal rates never mutes.
- R10: With long mode disabled by parameter, the mode input has no effect: the block stays in short mode and does not mute when the input rises.
- R11: Pointers wrap modulo the depth: a stream of more than 128 samples through an unmuted buffer returns every sample in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | Lag select: 0 short, 1 long |
| wr_en | input | 1 | Write strobe, one stereo sample per cycle |
| wr_left | input | SAMPLE_W | Left sample to write |
| wr_right | input | SAMPLE_W | Right sample to write |
| rd_en | input | 1 | Read strobe |
| rd_left | output | SAMPLE_W | Left sample read, registered; zero while muted |
| rd_right | output | SAMPLE_W | Right sample read, registered; zero while muted |
| mute | output | 1 | High from a recentring until fresh data is read |

## Verification
The first pattern is a short-mode sequence of interleaved, single-sided and idle strobes. It checks that the sixth read gives the first written sample, that an idle cycle holds the output, and that a drained buffer underflows. A long-mode entry followed by 96 muted reads separates the two lags by exactly one read, and a 300-cycle equal-rate stream shows that the pointers wrap without mute or loss. Filling to exactly the depth and then writing once more separates a full buffer from an overflow. A second instance built short-only shows that a toggled mode input is ignored.

// File: rtl/esf_pkg.sv
package esf_pkg;

  typedef enum logic {
    GD_SHORT = 1'b0,
    GD_LONG  = 1'b1
  } gd_mode_e;

endpackage

// File: rtl/esf_ptrs.sv
module esf_ptrs
  import esf_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int SHORT_LAG = 5,
  parameter int LONG_LAG  = 96,
  parameter bit LONG_EN   = 1'b1,
  localparam int AW       = $clog2(DEPTH),
  localparam int LW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] rp,
  output logic [LW-1:0] lag_cur,
  output logic          recenter
);

  localparam logic [LW-1:0] LAG_S = LW'(SHORT_LAG);
  localparam logic [LW-1:0] LAG_L = LW'(LONG_LAG);
  localparam logic [LW-1:0] FULL  = LW'(DEPTH);

  gd_mode_e      mode_q;
  gd_mode_e      mode_eff;
  logic [LW-1:0] lvl;
  logic [LW-1:0] lag_new;
  logic [AW-1:0] wp_n;
  logic          under, over, mode_chg;

  generate
    if (LONG_EN) begin : g_dual
      assign mode_eff = gd_mode_e'(mode_in);
    end else begin : g_short_only
      assign mode_eff = GD_SHORT;
    end
  endgenerate

  assign lag_cur  = (mode_q == GD_LONG) ? LAG_L : LAG_S;
  assign lag_new  = (mode_eff == GD_LONG) ? LAG_L : LAG_S;
  assign under    = rd_en && (lvl == '0);
  assign over     = wr_en && !rd_en && (lvl == FULL);
  assign mode_chg = (mode_eff != mode_q);
  assign recenter = under || over || mode_chg;
  assign wp_n     = wp + AW'(wr_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0 - LAG_S[AW-1:0];
      lvl    <= LAG_S;
      mode_q <= GD_SHORT;
    end else begin
      wp <= wp_n;
      if (recenter) begin
        rp     <= wp_n - lag_new[AW-1:0];
        lvl    <= lag_new;
        mode_q <= mode_eff;
      end else begin
        rp  <= rp + AW'(rd_en);
        lvl <= lvl + LW'(wr_en) - LW'(rd_en);
      end
    end
  end

  // R11
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lvl <= FULL);

  // R9
  ptr_span_chk: assert property (@(posedge clk) disable iff (rst)
    (wp - rp) == lvl[AW-1:0]);

  // R10
  short_only_chk: assert property (@(posedge clk) disable iff (rst)
    !LONG_EN |-> (lag_cur == LAG_S));

endmodule

// File: rtl/esf_mute.sv
module esf_mute #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          recenter,
  input  logic          rd_en,
  input  logic [LW-1:0] lag_cur,
  output logic          mute_next,
  output logic          mute_q
);

  logic [LW-1:0] cnt;
  logic          fresh_rd;

  assign fresh_rd  = mute_q && rd_en && (cnt == lag_cur);
  assign mute_next = recenter ? 1'b1 : (fresh_rd ? 1'b0 : mute_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_q <= 1'b1;
      cnt    <= '0;
    end else begin
      mute_q <= mute_next;
      if (recenter) begin
        cnt <= '0;
      end else if (mute_q && rd_en && !fresh_rd) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6
  unmute_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mute_q) |-> $past(rd_en));

  // R2
  cnt_window_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= lag_cur);

endmodule

// File: rtl/esf_store.sv
module esf_store #(
  parameter int DEPTH    = 128,
  parameter int SAMPLE_W = 24,
  localparam int AW      = $clog2(DEPTH),
  localparam int EW      = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wp,
  input  logic [EW-1:0]       wdata,
  input  logic                rd_en,
  input  logic [AW-1:0]       rp,
  input  logic                zero,
  output logic [EW-1:0]       rdata
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wp] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= mem[rp];
    end
  end

endmodule

// File: rtl/elastic_sample_fifo.sv
module elastic_sample_fifo #(
  parameter int DEPTH     = 128,
  parameter int SAMPLE_W  = 24,
  parameter int SHORT_LAG = 5,
  parameter int LONG_LAG  = 96,
  parameter bit LONG_EN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                long_mode,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_left,
  input  logic [SAMPLE_W-1:0] wr_right,
  input  logic                rd_en,
  output logic [SAMPLE_W-1:0] rd_left,
  output logic [SAMPLE_W-1:0] rd_right,
  output logic                mute
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int EW = 2 * SAMPLE_W;

  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lag_cur;
  logic          recenter, mute_next;
  logic [EW-1:0] rdata;

  esf_ptrs #(
    .DEPTH(DEPTH), .SHORT_LAG(SHORT_LAG), .LONG_LAG(LONG_LAG), .LONG_EN(LONG_EN)
  ) u_ptrs (
    .clk(clk), .rst(rst), .mode_in(long_mode), .wr_en(wr_en), .rd_en(rd_en),
    .wp(wp), .rp(rp), .lag_cur(lag_cur), .recenter(recenter)
  );

  esf_mute #(.LW(LW)) u_mute (
    .clk(clk), .rst(rst), .recenter(recenter), .rd_en(rd_en),
    .lag_cur(lag_cur), .mute_next(mute_next), .mute_q(mute)
  );

  esf_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wp(wp), .wdata({wr_left, wr_right}),
    .rd_en(rd_en), .rp(rp), .zero(mute_next), .rdata(rdata)
  );

  assign rd_left  = rdata[EW-1:SAMPLE_W];
  assign rd_right = rdata[SAMPLE_W-1:0];

  // R7
  muted_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mute |-> (rd_left == '0 && rd_right == '0));

  // R4
  cross_mute_chk: assert property (@(posedge clk) disable iff (rst)
    recenter |=> mute);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !recenter && !mute) |=> $stable(rdata));

endmodule

// File: tb/sim_elastic_sample_fifo.sv
module sim_elastic_sample_fifo;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        long_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [23:0] wl = '0, wr = '0;
  logic [23:0] rl0, rr0, rl1, rr1;
  logic        m0, m1;

  int n_chk = 0, n_fail = 0;
  int widx = 0;
  bit done = 0;

  always #2 clk = ~clk;

  elastic_sample_fifo u0 (
    .clk(clk), .rst(rst), .long_mode(long_mode), .wr_en(wr_en),
    .wr_left(wl), .wr_right(wr), .rd_en(rd_en),
    .rd_left(rl0), .rd_right(rr0), .mute(m0)
  );

  elastic_sample_fifo #(.LONG_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .long_mode(long_mode), .wr_en(wr_en),
    .wr_left(wl), .wr_right(wr), .rd_en(rd_en),
    .rd_left(rl1), .rd_right(rr1), .mute(m1)
  );

  // entry: {wr, rd, exp_mute, exp_idx[7:0]}; idx 0 means zero data
  localparam logic [10:0] VEC [19] = '{
    {1'b1,1'b0,1'b1,8'd0}, {1'b1,1'b1,1'b1,8'd0}, {1'b1,1'b1,1'b1,8'd0},
    {1'b0,1'b1,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0},
    {1'b0,1'b1,1'b0,8'd1}, {1'b1,1'b1,1'b0,8'd2}, {1'b0,1'b1,1'b0,8'd3},
    {1'b0,1'b0,1'b0,8'd3}, {1'b0,1'b1,1'b0,8'd4}, {1'b0,1'b1,1'b1,8'd0},
    {1'b1,1'b0,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0},
    {1'b0,1'b1,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0}, {1'b0,1'b1,1'b1,8'd0},
    {1'b0,1'b1,1'b0,8'd5}
  };

  function automatic logic [47:0] smp(int idx);
    if (idx == 0) return '0;
    return {24'h100000 | 24'(idx), 24'h200000 | 24'(idx)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit w, bit r);
    @(negedge clk);
    wr_en = w;
    rd_en = r;
    if (w) begin
      widx++;
      {wl, wr} = smp(widx);
    end
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic expect0(string req, bit em, int idx);
    chk(m0 == em, req, 64'(m0), 64'(em));
    chk({rl0, rr0} == smp(idx), req, 64'({rl0, rr0}), 64'(smp(idx)));
  endtask

  initial begin
    int exp_idx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    expect0("R1", 1'b1, 0);
    chk(m1 == 1'b1, "R1", 64'(m1), 64'd1);

    // R2 R4 R6 R7 R9 vector walk in short mode
    for (int i = 0; i < 19; i++) begin
      step(VEC[i][10], VEC[i][9]);
      expect0((i >= 11) ? "R4" : "R2", VEC[i][8], int'(VEC[i][7:0]));
    end

    // R8 switch to long; R10 short-only instance ignores it
    @(negedge clk);
    long_mode = 1'b1;
    step(1'b0, 1'b0);
    expect0("R8", 1'b1, 0);
    chk(m1 == 1'b0, "R10", 64'(m1), 64'd0);
    step(1'b0, 1'b0);
    chk(m1 == 1'b0, "R10", 64'(m1), 64'd0);

    // R3 long lag of 96
    exp_idx = widx + 1;
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    for (int k = 0; k < 96; k++) begin
      step(1'b0, 1'b1);
      expect0("R7", 1'b1, 0);
    end
    step(1'b0, 1'b1);
    expect0("R3", 1'b0, exp_idx);

    // R9 R11 equal-rate stream across wrap
    for (int k = 0; k < 300; k++) begin
      step(1'b1, 1'b1);
      exp_idx++;
      expect0("R11", 1'b0, exp_idx);
    end

    // R8 back to short, refill, unmute
    @(negedge clk);
    long_mode = 1'b0;
    step(1'b0, 1'b0);
    expect0("R8", 1'b1, 0);
    exp_idx = widx + 1;
    step(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1);
      expect0("R2", 1'b1, 0);
    end
    step(1'b0, 1'b1);
    expect0("R6", 1'b0, exp_idx);

    // R5 full at 128 is not overflow, 129th write is
    for (int k = 0; k < 128; k++) step(1'b1, 1'b0);
    chk(m0 == 1'b0, "R5", 64'(m0), 64'd0);
    step(1'b1, 1'b0);
    expect0("R5", 1'b1, 0);
    exp_idx = widx + 1;
    step(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
    expect0("R7", 1'b1, 0);
    step(1'b0, 1'b1);
    expect0("R6", 1'b0, exp_idx);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule